// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a streaming RGB display. A single write port loads eight interval counts. Each count is stored as the interval length minus one, and there is one count for each phase of a line and each phase of a frame. The block drives horizontal sync, vertical sync and data-enable, and gives each of these a polarity that can be programmed. It also gives the active pixel column and row to a downstream pixel path, together with a data polarity flag for that path. A vertical-sync interrupt has a sticky status bit and a mask bit.

Each direction runs the same four-state machine. The states are PH_ACTIVE, PH_FRONT, PH_SYNC and PH_BACK. The transition *advance* moves from each state to the next in that order when the interval count is used up, and the transition *wrap* goes from PH_BACK back to PH_ACTIVE. The horizontal machine steps on every clock while running. The vertical machine steps once per completed line. The transition *halt* forces both machines into PH_ACTIVE with a zero count whenever the run bit is clear.

The register map uses a 4-bit address. The address values and the bit positions of the fields are listed in the requirements.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the run bit is 0 and polarity is 4'b0011 (data-enable and data active-high, both syncs active-low). So de=0, hsync=1, vsync=1, pix_x=pix_y=0 and irq=0.
- R2: Each phase lasts (its register value + 1) clocks horizontally or lines vertically. This holds up to the largest value a CNT_W-bit register can store. Horizontal lengths are at addresses 0x4 (active), 0x5 (front), 0x6 (sync) and 0x7 (back). Vertical lengths are at 0x8, 0x9, 0xA and 0xB in the same order.
- R3: A line runs active, front porch, sync, back porch, then the next line. A frame follows the same order, counted in lines. hsync is asserted for the whole horizontal sync phase. vsync is asserted for every clock of the vertical sync lines.
- R4: de is asserted only when both directions are in their active phase. pix_x and pix_y then give the column and row, counted from 0. At all other times both are 0.
- R5: The polarity register is at 0x1. Bit 0 is for de, bit 1 is data_pol, bit 2 is for hsync and bit 3 is for vsync. A 1 makes that signal active-high and a 0 makes it active-low. Changes take effect on the next clock.
- R6: Writing bit 0 of address 0x0 sets or clears the run bit. While the run bit is clear, all outputs sit at their inactive levels and both counters are held at zero. Setting the run bit starts scanning at column 0 of row 0.
- R7: Writes to the interval registers during scanning take effect only after the last clock of the current frame. They also take effect at once while the block is stopped.
- R8: The status bit is set one clock after vsync becomes active (the leading edge). Writing 1 to bit 0 of address 0x3 clears it. A new leading edge in the same cycle wins over the clear.
- R9: irq equals the status bit ANDed with the mask bit, which is bit 0 of address 0x2.
- R10: Writes to addresses 0xC to 0xF change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Register write data |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data-enable, polarity applied |
| data_pol | output | 1 | Data polarity flag for the pixel path |
| pix_x | output | CNT_W | Active column, 0 outside the active area |
| pix_y | output | CNT_W | Active row, 0 outside the active area |
| irq | output | 1 | Masked vertical-sync interrupt |

## Verification
The bench builds the block with CNT_W = 8. This makes the largest interval value, 255, cheap enough to run as a full front porch inside a short frame. Most frames use small random interval counts of 0 to 5. Many complete frames therefore pass in a few thousand cycles. These frames cover single-clock phases, frame boundaries that arrive while a timing write is pending, and vsync leading edges that coincide with interrupt clears.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_t;

    localparam int N_PH = 4;

    localparam logic [3:0] A_RUN   = 4'h0;
    localparam logic [3:0] A_POL   = 4'h1;
    localparam logic [3:0] A_MASK  = 4'h2;
    localparam logic [3:0] A_STAT  = 4'h3;
    localparam logic [3:0] A_HBASE = 4'h4;
    localparam logic [3:0] A_VBASE = 4'h8;

    localparam int POL_DE   = 0;
    localparam int POL_DATA = 1;
    localparam int POL_HS   = 2;
    localparam int POL_VS   = 3;

    localparam logic [3:0] POL_RESET = 4'b0011;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             frame_end,
    output logic             run,
    output logic [3:0]       pol,
    output logic             mask,
    output logic             stat_clr,
    output logic [CNT_W-1:0] h_len [N_PH],
    output logic [CNT_W-1:0] v_len [N_PH]
);
    logic [CNT_W-1:0] h_live [N_PH];
    logic [CNT_W-1:0] v_live [N_PH];
    logic             shadow_load;

    assign stat_clr    = wr_en && (wr_addr == A_STAT) && wr_data[0];
    assign shadow_load = !run || frame_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            pol  <= POL_RESET;
            mask <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_RUN)  run  <= wr_data[0];
            if (wr_addr == A_POL)  pol  <= wr_data[3:0];
            if (wr_addr == A_MASK) mask <= wr_data[0];
        end
    end

    for (genvar g = 0; g < N_PH; g++) begin : g_len
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                h_live[g] <= '0;
                v_live[g] <= '0;
                h_len[g]  <= '0;
                v_len[g]  <= '0;
            end else begin
                if (wr_en && wr_addr == A_HBASE + 4'(g)) h_live[g] <= wr_data;
                if (wr_en && wr_addr == A_VBASE + 4'(g)) v_live[g] <= wr_data;
                if (shadow_load) begin
                    h_len[g] <= h_live[g];
                    v_len[g] <= v_live[g];
                end
            end
        end

        // R7
        h_shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run) && !$past(frame_end)) |-> $stable(h_len[g]));
        // R7
        v_shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run) && !$past(frame_end)) |-> $stable(v_len[g]));
    end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] lens [N_PH],
    output phase_t           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    phase_t           ph_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             at_end;
    logic [1:0]       ph_bits;

    assign at_end  = (cnt == lens[phase]);
    assign last    = step && (phase == PH_BACK) && at_end;
    assign ph_bits = phase;

    always_comb begin
        ph_nxt  = phase;
        cnt_nxt = cnt;
        if (!run) begin
            ph_nxt  = PH_ACTIVE;
            cnt_nxt = '0;
        end else if (step) begin
            if (at_end) begin
                cnt_nxt = '0;
                unique case (phase)
                    PH_ACTIVE: ph_nxt = PH_FRONT;
                    PH_FRONT:  ph_nxt = PH_SYNC;
                    PH_SYNC:   ph_nxt = PH_BACK;
                    PH_BACK:   ph_nxt = PH_ACTIVE;
                endcase
            end else begin
                cnt_nxt = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_ACTIVE;
            cnt   <= '0;
        end else begin
            phase <= ph_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt <= lens[phase]));
    // R3
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (ph_bits != $past(ph_bits))) |-> (ph_bits == $past(ph_bits) + 2'd1));
endmodule

// File: rtl/rtg_irq.sv
module rtg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_act,
    input  logic clr,
    input  logic mask,
    output logic irq
);
    logic vs_q;
    logic stat;
    logic edge_seen;

    assign edge_seen = vs_act && !vs_q;
    assign irq       = stat && mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
            stat <= 1'b0;
        end else begin
            vs_q <= vs_act;
            if (edge_seen)  stat <= 1'b1;
            else if (clr)   stat <= 1'b0;
        end
    end

    // R8
    stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> ($past(vs_act) && !$past(vs_q)));
    // R8
    stat_edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_act && !vs_q) |=> stat);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             data_pol,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] pix_y,
    output logic             irq
);
    logic             run;
    logic [3:0]       pol;
    logic             mask;
    logic             stat_clr;
    logic [CNT_W-1:0] h_len [N_PH];
    logic [CNT_W-1:0] v_len [N_PH];
    phase_t           h_ph, v_ph;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             h_last, v_last;
    logic             de_act, hs_act, vs_act;

    rtg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(v_last), .run(run), .pol(pol),
        .mask(mask), .stat_clr(stat_clr), .h_len(h_len), .v_len(v_len)
    );

    rtg_axis #(.CNT_W(CNT_W)) u_h (
        .clk(clk), .rst_n(rst_n), .run(run), .step(run), .lens(h_len),
        .phase(h_ph), .cnt(h_cnt), .last(h_last)
    );

    rtg_axis #(.CNT_W(CNT_W)) u_v (
        .clk(clk), .rst_n(rst_n), .run(run), .step(h_last), .lens(v_len),
        .phase(v_ph), .cnt(v_cnt), .last(v_last)
    );

    rtg_irq u_irq (
        .clk(clk), .rst_n(rst_n), .vs_act(vs_act), .clr(stat_clr),
        .mask(mask), .irq(irq)
    );

    always_comb begin
        de_act   = run && (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);
        hs_act   = run && (h_ph == PH_SYNC);
        vs_act   = run && (v_ph == PH_SYNC);
        de       = pol[POL_DE] ? de_act : !de_act;
        hsync    = pol[POL_HS] ? hs_act : !hs_act;
        vsync    = pol[POL_VS] ? vs_act : !vs_act;
        data_pol = pol[POL_DATA];
        pix_x    = de_act ? h_cnt : '0;
        pix_y    = de_act ? v_cnt : '0;
    end

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (h_cnt == '0 && v_cnt == '0));
    // R3
    vline_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(h_last)) |-> $stable(v_cnt));
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          hsync, vsync, de, data_pol, irq;
    logic [CW-1:0] pix_x, pix_y;

    raster_timing_gen #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
        .data_pol(data_pol), .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    // bench reference state
    int m_run, m_pol, m_mask, m_stat, m_vsq, hpos, vpos;
    int m_hl[4], m_vl[4], m_hs[4], m_vs[4];

    function automatic int phase_of(int pos, int l0, int l1, int l2);
        if (pos <= l0) return 0;
        pos -= l0 + 1;
        if (pos <= l1) return 1;
        pos -= l1 + 1;
        if (pos <= l2) return 2;
        return 3;
    endfunction

    function automatic int exp_vec();
        int hp, vp, e_de, e_hs, e_vs, ex, ey, e_irq;
        hp = phase_of(hpos, m_hs[0], m_hs[1], m_hs[2]);
        vp = phase_of(vpos, m_vs[0], m_vs[1], m_vs[2]);
        e_de = (m_run != 0 && hp == 0 && vp == 0) ? 1 : 0;
        e_hs = (m_run != 0 && hp == 2) ? 1 : 0;
        e_vs = (m_run != 0 && vp == 2) ? 1 : 0;
        ex = e_de ? hpos : 0;
        ey = e_de ? vpos : 0;
        e_irq = m_stat & m_mask;
        if (!m_pol[0]) e_de = 1 - e_de;
        if (!m_pol[2]) e_hs = 1 - e_hs;
        if (!m_pol[3]) e_vs = 1 - e_vs;
        return (e_de << 20) | (e_hs << 19) | (e_vs << 18) | (m_pol[1] << 17) |
               (e_irq << 16) | (ex << 8) | ey;
    endfunction

    function automatic int act_vec();
        return (int'(de) << 20) | (int'(hsync) << 19) | (int'(vsync) << 18) |
               (int'(data_pol) << 17) | (int'(irq) << 16) | (int'(pix_x) << 8) | int'(pix_y);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic model_step(bit we, int a, int d);
        int hp, vp, htot, vtot, vs_a, nstat, fend;
        hp = phase_of(hpos, m_hs[0], m_hs[1], m_hs[2]);
        vp = phase_of(vpos, m_vs[0], m_vs[1], m_vs[2]);
        vs_a = (m_run != 0 && vp == 2) ? 1 : 0;
        nstat = (vs_a && !m_vsq) ? 1 : ((m_stat && !(we && a == 3 && d[0])) ? 1 : 0);
        m_vsq = vs_a;
        htot = m_hs[0] + m_hs[1] + m_hs[2] + m_hs[3] + 4;
        vtot = m_vs[0] + m_vs[1] + m_vs[2] + m_vs[3] + 4;
        if (m_run == 0) begin
            hpos = 0; vpos = 0;
            fend = 1;
        end else begin
            fend = (hpos == htot - 1 && vpos == vtot - 1) ? 1 : 0;
            hpos++;
            if (hpos == htot) begin
                hpos = 0;
                vpos++;
                if (vpos == vtot) vpos = 0;
            end
        end
        if (fend) begin
            for (int i = 0; i < 4; i++) begin m_hs[i] = m_hl[i]; m_vs[i] = m_vl[i]; end
        end
        if (we) begin
            if (a == 0) m_run = d & 1;
            if (a == 1) m_pol = d & 15;
            if (a == 2) m_mask = d & 1;
            if (a >= 4 && a <= 7) m_hl[a-4] = d & CMAX;
            if (a >= 8 && a <= 11) m_vl[a-8] = d & CMAX;
        end
        m_stat = nstat;
    endtask

    // one clock: drive at negedge, compare, edge, advance reference
    task automatic cyc(bit we, int a, int d);
        int e;
        wr_en = we; wr_addr = a[3:0]; wr_data = d[CW-1:0];
        #1;
        e = exp_vec();
        chk(act_vec() == e, cur_req, act_vec(), e);
        @(posedge clk);
        model_step(we, a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    initial begin
        int s, act, r, a, cnt_de;
        s = $urandom(32'h5eed);
        m_run = 0; m_pol = 3; m_mask = 0; m_stat = 0; m_vsq = 0; hpos = 0; vpos = 0;
        for (int i = 0; i < 4; i++) begin m_hl[i] = 0; m_vl[i] = 0; m_hs[i] = 0; m_vs[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset levels
        act = act_vec();
        chk(de == 0 && hsync == 1 && vsync == 1 && irq == 0 && pix_x == 0 && pix_y == 0,
            "R1", act, 32'h000C_0000 | 32'h0002_0000);

        // R3 line/frame ordering with distinct lengths
        cur_req = "R3";
        cyc(1, 4, 3); cyc(1, 5, 1); cyc(1, 6, 2); cyc(1, 7, 1);
        cyc(1, 8, 2); cyc(1, 9, 0); cyc(1, 10, 1); cyc(1, 11, 0);
        cyc(1, 2, 1);
        cyc(1, 0, 1);
        idle(2 * 11 * 7 + 5);

        // R4 first active pixel after a restart, and de count in one line
        cur_req = "R4";
        cyc(1, 0, 0); cyc(1, 0, 1);
        cnt_de = 0;
        for (int i = 0; i < 4; i++) begin
            if (de) cnt_de++;
            cyc(0, 0, 0);
        end
        chk(cnt_de == 4, "R4", cnt_de, 4);

        // R6 stop mid-frame: outputs inactive, then restart at origin
        cur_req = "R6";
        idle(17);
        cyc(1, 0, 0);
        #1;
        chk(de == 0 && hsync == 1 && vsync == 1 && pix_x == 0 && pix_y == 0, "R6",
            act_vec(), exp_vec());
        idle(6);
        cyc(1, 0, 1);
        idle(30);

        // R2 largest interval value in the horizontal front porch
        cur_req = "R2";
        cyc(1, 5, CMAX);
        idle(3 * 11 * 7);
        idle(2 * (CMAX + 8) * 7);

        // R7 mid-frame rewrite of every interval
        cur_req = "R7";
        cyc(1, 5, 1);
        idle(4 * (CMAX + 8));
        idle(5);
        cyc(1, 4, 1); idle(3); cyc(1, 8, 3); idle(2); cyc(1, 6, 0);
        idle(3 * 12 * 9);

        // random mix
        for (int it = 0; it < 300; it++) begin
            r = $urandom_range(0, 9);
            case (r)
                0: begin cur_req = "R5"; cyc(1, 1, $urandom_range(0, 15)); end
                1: begin cur_req = "R8"; cyc(1, 3, $urandom_range(0, 3)); end
                2: begin cur_req = "R9"; cyc(1, 2, $urandom_range(0, 1)); end
                3: begin cur_req = "R7"; a = $urandom_range(4, 11); cyc(1, a, $urandom_range(0, 5)); end
                4: begin cur_req = "R10"; a = $urandom_range(12, 15); cyc(1, a, $urandom_range(0, CMAX)); end
                5: begin cur_req = "R6"; cyc(1, 0, $urandom_range(0, 1)); end
                default: begin cur_req = "R3"; cyc(1, 0, 1); end
            endcase
            idle($urandom_range(0, 40));
        end

        // R8 clears attempted on every cycle around a few frames
        cur_req = "R8";
        cyc(1, 2, 1);
        for (int i = 0; i < 600; i++) cyc(($urandom_range(0, 2) == 0), 3, 1);

        // R9 mask off hides a pending status, mask on reveals it
        cur_req = "R9";
        cyc(1, 2, 0);
        idle(400);
        cyc(1, 2, 1);
        idle(5);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(150_000 * 10);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule